// File: doc/BRIEF.md
# Packed 36-bit Word Unpacker

This block rebuilds 36-bit memory words from a stream of 32-bit bus words. The data arrives in fixed groups of nine bus words. Each group yields eight memory words. The first eight bus words of a group carry the low 32 bits of the eight memory words, in order. The ninth bus word carries the four top bits of all eight memory words. Memory word 0 takes its top bits from the most significant nibble of the ninth word, and memory word 7 takes them from the least significant nibble.

The eight low words are held in a local buffer until the ninth word arrives. After that, the eight merged words go out on a valid/ready stream, one per cycle while the consumer is ready. The last word of each group is flagged. The input side is held off while a complete group is still being emitted. A synchronous clear returns the block to the start of a group. It drops any partial group and any words not yet emitted, so that a caller can realign the decoding at a group boundary.

Top module: `slice_unpack36`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Bits [31:0] of output word i of a group equal input word i of that group, for i from 0 to 7.
- R3: Bits [35:32] of output word i equal bits [31-4i:28-4i] of input word 8 of the same group. Word 0 takes bits [31:28] and word 7 takes bits [3:0].
- R4: out_valid stays 0 until the ninth input word of a group has been accepted. It rises in the cycle after that acceptance.
- R5: in_ready is 0 whenever out_valid is 1, so no input word is taken while a group is being emitted.
- R6: Each group produces exactly eight output words in index order. While out_ready is 0, out_data and out_valid hold their values.
- R7: out_last is 1 on the eighth output word of a group and 0 on the other seven.
- R8: A cycle with clr high discards a partial group and any words not yet emitted. In the next cycle out_valid is 0 and in_ready is 1, and the next accepted input word is treated as word 0 of a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous realign to a group boundary |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 32 | 32-bit bus word |
| out_valid | output | 1 | Merged word available |
| out_ready | input | 1 | Consumer takes the merged word |
| out_data | output | 36 | Merged 36-bit memory word |
| out_last | output | 1 | Marks the eighth word of a group |

## Verification
The hardest conditions to reach from the ports are a clear that arrives in the middle of a group and a clear that arrives in the middle of draining. Both must leave no trace in later output.

The bench reaches them with directed sequences. In the first, it sends five words and pulses clr. In the second, it lets a group start draining, takes three words and then pulses clr. In both cases a fresh group must come out intact.

Random valid and ready gaps cover the cases where the output stalls on every word and where a new group starts directly after the last word is taken. Patterns of all zeros, all ones and walking nibbles in the ninth word check that each nibble reaches the correct output word.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

   typedef enum logic [0:0] {
      PH_FILL  = 1'b0,
      PH_DRAIN = 1'b1
   } unpack_phase_e;

endpackage

// File: rtl/unpack_lo_store.sv
module unpack_lo_store #(
   parameter int LO_W  = 32,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [LO_W-1:0] wdata,
   input  logic [AW-1:0]   raddr,
   output logic [LO_W-1:0] rdata
);

   logic [LO_W-1:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(g))) mem[g] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/unpack_nib_pick.sv
module unpack_nib_pick #(
   parameter int  HI_W      = 4,
   parameter int  WORDS     = 8,
   parameter bit  MSB_FIRST = 1'b1,
   localparam int SRC_W     = HI_W * WORDS,
   localparam int IW        = $clog2(WORDS)
) (
   input  logic [SRC_W-1:0] src,
   input  logic [IW-1:0]    idx,
   output logic [HI_W-1:0]  nib
);

   if (MSB_FIRST) begin : g_msb_first
      always_comb nib = src[(SRC_W - 1 - HI_W * int'(idx)) -: HI_W];
   end else begin : g_lsb_first
      always_comb nib = src[(HI_W * int'(idx)) +: HI_W];
   end

endmodule

// File: rtl/unpack_seq.sv
module unpack_seq
   import unpack_pkg::*;
#(
   parameter int  WORDS = 8,
   localparam int IW    = $clog2(WORDS),
   localparam int CW    = $clog2(WORDS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          out_ready,
   output logic          out_valid,
   output logic          out_last,
   output logic          lo_we,
   output logic [IW-1:0] lo_waddr,
   output logic          hi_we,
   output logic [IW-1:0] rd_idx
);

   localparam logic [CW-1:0] HI_SLOT = CW'(WORDS);
   localparam logic [IW-1:0] LAST    = IW'(WORDS - 1);

   unpack_phase_e phase;
   logic [CW-1:0] in_cnt;
   logic          in_fire, out_fire;

   assign in_ready  = (phase == PH_FILL);
   assign out_valid = (phase == PH_DRAIN);
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;
   assign lo_we     = in_fire && (in_cnt != HI_SLOT);
   assign hi_we     = in_fire && (in_cnt == HI_SLOT);
   assign lo_waddr  = in_cnt[IW-1:0];
   assign out_last  = out_valid && (rd_idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_FILL;
         in_cnt <= '0;
         rd_idx <= '0;
      end else if (clr) begin
         phase  <= PH_FILL;
         in_cnt <= '0;
         rd_idx <= '0;
      end else begin
         if (hi_we) begin
            phase  <= PH_DRAIN;
            in_cnt <= '0;
            rd_idx <= '0;
         end else if (lo_we) begin
            in_cnt <= in_cnt + CW'(1);
         end
         if (out_fire) begin
            rd_idx <= rd_idx + IW'(1);
            if (rd_idx == LAST) phase <= PH_FILL;
         end
      end
   end

endmodule

// File: rtl/slice_unpack36.sv
module slice_unpack36 #(
   parameter int  LO_W      = 32,
   parameter int  HI_W      = 4,
   parameter int  WORDS     = 8,
   parameter bit  MSB_FIRST = 1'b1,
   localparam int OUT_W     = LO_W + HI_W,
   localparam int IW        = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [LO_W-1:0]  in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_data,
   output logic             out_last
);

   if (HI_W * WORDS != LO_W) begin : g_bad_pack
      $error("slice_unpack36: HI_W*WORDS must equal LO_W");
   end
   if ((WORDS < 2) || ((1 << IW) != WORDS)) begin : g_bad_words
      $error("slice_unpack36: WORDS must be a power of two of at least 2");
   end

   logic            lo_we, hi_we;
   logic [IW-1:0]   lo_waddr, rd_idx;
   logic [LO_W-1:0] lo_rd;
   logic [LO_W-1:0] hi_word;
   logic [HI_W-1:0] nib;

   unpack_seq #(.WORDS(WORDS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_last  (out_last),
      .lo_we     (lo_we),
      .lo_waddr  (lo_waddr),
      .hi_we     (hi_we),
      .rd_idx    (rd_idx)
   );

   unpack_lo_store #(.LO_W(LO_W), .DEPTH(WORDS)) u_store (
      .clk   (clk),
      .we    (lo_we),
      .waddr (lo_waddr),
      .wdata (in_data),
      .raddr (rd_idx),
      .rdata (lo_rd)
   );

   always_ff @(posedge clk) begin
      if (hi_we) hi_word <= in_data;
   end

   unpack_nib_pick #(.HI_W(HI_W), .WORDS(WORDS), .MSB_FIRST(MSB_FIRST)) u_pick (
      .src (hi_word),
      .idx (rd_idx),
      .nib (nib)
   );

   assign out_data = {nib, lo_rd};

endmodule

// File: rtl/slice_unpack36_chk.sv
module slice_unpack36_chk #(
   parameter int  OUT_W = 36,
   parameter int  WORDS = 8,
   localparam int IW    = $clog2(WORDS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_data,
   input logic             out_last
);

   logic [IW-1:0] ocnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ocnt <= '0;
      else if (clr)                    ocnt <= '0;
      else if (out_valid && out_ready) ocnt <= ocnt + IW'(1);
   end

   // R5
   p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R4
   p_start_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready && !clr));

   // R6
   p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

   // R7
   p_last_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_last == (ocnt == IW'(WORDS - 1))));

   // R8
   p_clear_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!out_valid && in_ready));

endmodule

bind slice_unpack36 slice_unpack36_chk #(.OUT_W(OUT_W), .WORDS(WORDS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last)
);

// File: tb/slice_unpack36_bench.sv
module slice_unpack36_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [35:0] out_data;
   logic        out_last;

   always #(CLK_PERIOD/2) clk = ~clk;

   slice_unpack36 u_slice_unpack36 (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic [31:0] in_q[$];
   logic [35:0] exp_q[$];
   int          sent_in_group = 0;
   bit          exp_drain = 1'b0;
   int          out_idx = 0;
   bit          prev_stall = 1'b0;
   logic [35:0] prev_data = '0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] merged(input logic [31:0] lo, input logic [31:0] hi,
                                          input int i);
      return {hi[31-4*i -: 4], lo};
   endfunction

   task automatic add_group(input logic [31:0] lows[8], input logic [31:0] hi);
      for (int i = 0; i < 8; i++) begin
         in_q.push_back(lows[i]);
         exp_q.push_back(merged(lows[i], hi, i));
      end
      in_q.push_back(hi);
   endtask

   task automatic add_random_group();
      logic [31:0] lows[8];
      for (int i = 0; i < 8; i++) lows[i] = $urandom;
      add_group(lows, $urandom);
   endtask

   // one cycle: check outputs seen now, drive the next handshake
   task automatic step(input int vpct, input int rpct);
      bit v, r;
      @(negedge clk);
      check(out_valid == exp_drain, "R4", 64'(out_valid), 64'(exp_drain));
      if (out_valid) check(!in_ready, "R5", 64'(in_ready), 64'd0);
      if (prev_stall) check(out_data == prev_data, "R6", 64'(out_data), 64'(prev_data));
      v = (in_q.size() != 0) && (($urandom % 100) < vpct);
      r = (($urandom % 100) < rpct);
      in_valid  = v;
      in_data   = v ? in_q[0] : '0;
      out_ready = r;
      if (v && in_ready) begin
         void'(in_q.pop_front());
         sent_in_group++;
         if (sent_in_group == 9) begin
            sent_in_group = 0;
            exp_drain = 1'b1;
            out_idx = 0;
         end
      end
      prev_stall = out_valid && !r;
      prev_data  = out_data;
      if (out_valid && r) begin
         logic [35:0] e;
         e = (exp_q.size() != 0) ? exp_q.pop_front() : '0;
         check(out_data[31:0] == e[31:0], "R2", 64'(out_data[31:0]), 64'(e[31:0]));
         check(out_data[35:32] == e[35:32], "R3", 64'(out_data[35:32]), 64'(e[35:32]));
         check(out_last == (out_idx == 7), "R7", 64'(out_last), 64'(out_idx == 7));
         out_idx++;
         if (out_idx == 8) begin
            out_idx = 0;
            exp_drain = 1'b0;
         end
      end
   endtask

   task automatic run_idle(input int vpct, input int rpct);
      int guard = 0;
      while ((in_q.size() != 0 || exp_drain) && guard < 20000) begin
         step(vpct, rpct);
         guard++;
      end
      check(exp_q.size() == 0, "R6", 64'(exp_q.size()), 64'd0);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check(!out_valid, "R8", 64'(out_valid), 64'd0);
      check(in_ready, "R8", 64'(in_ready), 64'd1);
      in_q.delete(); exp_q.delete();
      sent_in_group = 0; exp_drain = 1'b0; out_idx = 0; prev_stall = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] lows[8];
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(!out_valid, "R1", 64'(out_valid), 64'd0);
      check(in_ready, "R1", 64'(in_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R1", 64'(out_valid), 64'd0);
      check(in_ready, "R1", 64'(in_ready), 64'd1);

      // directed nibble patterns
      for (int i = 0; i < 8; i++) lows[i] = 32'h1111_1111 * i;
      add_group(lows, 32'h0000_0000);
      add_group(lows, 32'hFFFF_FFFF);
      add_group(lows, 32'h0123_4567);
      add_group(lows, 32'hF000_000F);
      for (int k = 0; k < 8; k++) add_group(lows, 32'h8000_0000 >> (4 * k));
      run_idle(100, 100);

      // R4: out_valid must stay low with only eight words sent
      for (int i = 0; i < 8; i++) in_q.push_back($urandom);
      run_idle(100, 100);
      repeat (5) step(100, 100);
      check(!out_valid, "R4", 64'(out_valid), 64'd0);

      // R8: clear mid-fill, then a fresh group must come out intact
      pulse_clear();
      for (int i = 0; i < 5; i++) in_q.push_back($urandom);
      run_idle(100, 100);
      pulse_clear();
      add_random_group();
      run_idle(100, 100);

      // R8: clear mid-drain
      add_random_group();
      while (!exp_drain) step(100, 0);
      for (int i = 0; i < 3; i++) step(0, 100);
      pulse_clear();
      add_random_group();
      run_idle(100, 100);

      // R6 stalls and random gaps
      for (int n = 0; n < 40; n++) add_random_group();
      run_idle(60, 40);
      for (int n = 0; n < 40; n++) add_random_group();
      run_idle(100, 15);
      for (int n = 0; n < 40; n++) add_random_group();
      run_idle(100, 100);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule